// File: doc/BRIEF.md
# Packed Single-Precision Min/Max Unit

This block takes two 128-bit vectors, a destination operand and a source operand. Each vector holds four IEEE-754 single-precision lanes. For each lane the block returns either the smaller or the larger of the two values. A mode input chooses minimum or maximum. A second input chooses packed operation, where all four lanes are computed, or scalar operation, where only the lowest lane is computed and the upper three lanes are copied from the destination operand.

The selection rule is deliberately asymmetric, so the block is not commutative. If either lane holds a NaN, or if the two lanes compare equal (which includes +0 against -0), the source lane is returned bit for bit. The ordering itself uses no subtraction. Each value is mapped to an unsigned key that follows sign-magnitude order, and the two keys are compared. Infinities are treated as ordinary ordered values. Exception flags and denormal handling are not part of this block.

The result is registered. It appears, together with a one-cycle done pulse, on the clock edge that follows the valid strobe.

Top module: `fminmax_vec`

## Requirements
- R1: While reset is high, and in the cycle after reset, `done_o` is 0 and `res_o` is all zeros.
- R2: `done_o` is high in exactly the cycle after each cycle in which `in_valid` is sampled high, and low otherwise.
- R3: If either lane is a NaN, the result lane equals the source lane bit for bit. A NaN has exponent bits [30:23] of the lane all ones and fraction bits [22:0] nonzero.
- R4: If the two lanes are numerically equal, the result lane is the source lane. This includes +0 (0x00000000) against -0 (0x80000000).
- R5: When `op_max` is 0, the result lane is the numerically smaller of two ordered, unequal lanes.
- R6: When `op_max` is 1, the result lane is the numerically larger of two ordered, unequal lanes.
- R7: Infinities (exponent all ones, fraction zero) are ordered. -inf is below every other non-NaN value and +inf is above every other non-NaN value.
- R8: When `scalar` is 1, lane 0 (bits [31:0]) is computed, and bits [127:32] of the result equal the destination operand.
- R9: When `scalar` is 0, each of the four lanes (lane k in bits [32k+31:32k]) is computed independently of the others.
- R10: In cycles where `in_valid` is low, `res_o` holds its previous value whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| op_max | input | 1 | 0 selects minimum, 1 selects maximum |
| scalar | input | 1 | 1 computes lane 0 only and passes the destination's upper lanes through |
| dst_i | input | 128 | Destination operand, four 32-bit lanes |
| src_i | input | 128 | Source operand, four 32-bit lanes |
| res_o | output | 128 | Registered result vector |
| done_o | output | 1 | One-cycle pulse marking a new result |

## Verification
The hardest cases to hit with random stimulus are lanes that are equal but have different bit patterns (signed zeros), and NaNs whose payloads differ between operands. Uniform random words almost never produce these. The stimulus therefore draws each lane from a pool of special encodings (both zeros, both infinities, quiet and signalling NaNs with distinct payloads, negative normals) about half of the time. Directed vectors place a different special case in each lane of one vector, so that any crosstalk between lanes shows up. The bench's reference orders values by comparing the sign first and then the magnitude, which is a different method from the key comparison used in the design.

// File: rtl/fmm_pkg.sv
package fmm_pkg;
  typedef enum logic {
    MODE_MIN = 1'b0,
    MODE_MAX = 1'b1
  } fmm_mode_e;
endpackage

// File: rtl/fmm_class.sv
module fmm_class #(
  parameter int W     = 32,
  parameter int EXP_W = 8
) (
  input  logic [W-1:0] val,
  output logic         is_nan,
  output logic         is_zero,
  output logic [W-1:0] key
);
  localparam int MAN_W = W - 1 - EXP_W;

  logic             sgn;
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] man;

  assign sgn = val[W-1];
  assign ex  = val[W-2 -: EXP_W];
  assign man = val[MAN_W-1:0];

  always_comb begin
    is_nan  = (&ex) && (|man);
    is_zero = ~|val[W-2:0];
    // positive values above all negatives; negatives ordered by inverted magnitude
    key     = sgn ? {1'b0, ~val[W-2:0]} : {1'b1, val[W-2:0]};
  end
endmodule

// File: rtl/fmm_lane.sv
module fmm_lane
  import fmm_pkg::*;
#(
  parameter int W     = 32,
  parameter int EXP_W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  fmm_mode_e    mode,
  output logic [W-1:0] y
);
  logic         a_nan, b_nan, a_zero, b_zero;
  logic [W-1:0] a_key, b_key;
  logic         a_below, same;

  fmm_class #(.W(W), .EXP_W(EXP_W)) u_cls_a (
    .val(a), .is_nan(a_nan), .is_zero(a_zero), .key(a_key)
  );
  fmm_class #(.W(W), .EXP_W(EXP_W)) u_cls_b (
    .val(b), .is_nan(b_nan), .is_zero(b_zero), .key(b_key)
  );

  always_comb begin
    a_below = a_key < b_key;
    same    = (a == b) || (a_zero && b_zero);
    if (a_nan || b_nan || same)
      y = b;
    else if (mode == MODE_MAX)
      y = a_below ? b : a;
    else
      y = a_below ? a : b;
  end
endmodule

// File: rtl/fminmax_vec.sv
module fminmax_vec #(
  parameter int LANES  = 4,
  parameter int LANE_W = 32,
  parameter int EXP_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    op_max,
  input  logic                    scalar,
  input  logic [LANES*LANE_W-1:0] dst_i,
  input  logic [LANES*LANE_W-1:0] src_i,
  output logic [LANES*LANE_W-1:0] res_o,
  output logic                    done_o
);
  import fmm_pkg::*;
  localparam int VEC_W = LANES * LANE_W;

  fmm_mode_e        mode;
  logic [VEC_W-1:0] nxt;

  assign mode = op_max ? MODE_MAX : MODE_MIN;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_y;
    fmm_lane #(.W(LANE_W), .EXP_W(EXP_W)) u_lane (
      .a   (dst_i[g*LANE_W +: LANE_W]),
      .b   (src_i[g*LANE_W +: LANE_W]),
      .mode(mode),
      .y   (lane_y)
    );
    if (g == 0) begin : g_low
      assign nxt[LANE_W-1:0] = lane_y;
    end else begin : g_up
      assign nxt[g*LANE_W +: LANE_W] = scalar ? dst_i[g*LANE_W +: LANE_W] : lane_y;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= in_valid;
      if (in_valid) res_o <= nxt;
    end
  end
endmodule

// File: rtl/fmm_chk.sv
module fmm_chk #(
  parameter int LANES  = 4,
  parameter int LANE_W = 32,
  parameter int EXP_W  = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    op_max,
  input logic                    scalar,
  input logic [LANES*LANE_W-1:0] dst_i,
  input logic [LANES*LANE_W-1:0] src_i,
  input logic [LANES*LANE_W-1:0] res_o,
  input logic                    done_o
);
  localparam int VEC_W = LANES * LANE_W;
  localparam int MAN_W = LANE_W - 1 - EXP_W;

  logic lane0_nan;
  assign lane0_nan =
    ((&src_i[LANE_W-2 -: EXP_W]) && (|src_i[MAN_W-1:0])) ||
    ((&dst_i[LANE_W-2 -: EXP_W]) && (|dst_i[MAN_W-1:0]));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (done_o == 1'b0 && res_o == '0));

  // R2
  done_after_valid_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> done_o);

  // R2
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !done_o);

  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(res_o));

  // R8
  scalar_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && scalar) |=> res_o[VEC_W-1:LANE_W] == $past(dst_i[VEC_W-1:LANE_W]));

  // R3
  nan_src_lane0_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && lane0_nan) |=> res_o[LANE_W-1:0] == $past(src_i[LANE_W-1:0]));
endmodule

bind fminmax_vec fmm_chk #(.LANES(LANES), .LANE_W(LANE_W), .EXP_W(EXP_W)) u_chk (.*);

// File: tb/fminmax_vec_bench.sv
module fminmax_vec_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         op_max = 1'b0;
  logic         scalar = 1'b0;
  logic [127:0] dst_i = '0;
  logic [127:0] src_i = '0;
  logic [127:0] res_o;
  logic         done_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fminmax_vec u_fminmax_vec (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_max(op_max), .scalar(scalar),
    .dst_i(dst_i), .src_i(src_i), .res_o(res_o), .done_o(done_o)
  );

  function automatic bit f_nan(input logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 0);
  endfunction

  function automatic bit f_less(input logic [31:0] p, input logic [31:0] q);
    if (p[31] != q[31]) return p[31];
    if (p[31] == 1'b0) return p[30:0] < q[30:0];
    return p[30:0] > q[30:0];
  endfunction

  function automatic logic [31:0] f_ref(input logic [31:0] d, input logic [31:0] s, input bit mx);
    if (f_nan(d) || f_nan(s)) return s;
    if (d == s || (d[30:0] == 0 && s[30:0] == 0)) return s;
    if (mx) return f_less(s, d) ? d : s;
    return f_less(d, s) ? d : s;
  endfunction

  function automatic logic [127:0] f_vec(input logic [127:0] d, input logic [127:0] s,
                                         input bit mx, input bit sc);
    logic [127:0] r;
    for (int k = 0; k < 4; k++)
      r[k*32 +: 32] = (sc && k > 0) ? d[k*32 +: 32] : f_ref(d[k*32 +: 32], s[k*32 +: 32], mx);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // apply one operation, check the result and the idle hold
  task automatic run(input logic [127:0] d, input logic [127:0] s, input bit mx,
                     input bit sc, input string req);
    logic [127:0] e;
    e = f_vec(d, s, mx, sc);
    dst_i = d; src_i = s; op_max = mx; scalar = sc; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(done_o == 1'b1, "R2", {127'b0, done_o}, 128'd1);
    check(res_o == e, req, res_o, e);
    dst_i = ~d; src_i = d ^ s; op_max = ~mx;
    @(negedge clk);
    check(done_o == 1'b0, "R2", {127'b0, done_o}, 128'd0);
    check(res_o == e, "R10", res_o, e);
  endtask

  function automatic logic [31:0] pick();
    logic [31:0] pool [12];
    pool = '{32'h00000000, 32'h80000000, 32'h7F800000, 32'hFF800000,
             32'h7FC00001, 32'hFFA00005, 32'h3F800000, 32'hBF800000,
             32'h00000001, 32'h80000001, 32'h7F7FFFFF, 32'hFF7FFFFF};
    if ($urandom_range(1, 0) == 0) return pool[$urandom_range(11, 0)];
    return $urandom();
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4051));
    repeat (2) @(negedge clk);
    // R1: outputs during reset
    check(done_o == 1'b0 && res_o == '0, "R1", res_o, '0);
    rst = 1'b0;
    @(negedge clk);
    check(done_o == 1'b0 && res_o == '0, "R1", res_o, '0);

    // R3: NaN in dst lane, NaN in src lane, both NaN, payload preserved
    run({32'h7FC00001, 32'h3F800000, 32'hFFA00005, 32'h7FC12345},
        {32'h40000000, 32'h7FC0BEEF, 32'hFFC00009, 32'hBF800000}, 1'b0, 1'b0, "R3");
    run({32'h7FC00001, 32'h3F800000, 32'hFFA00005, 32'h7FC12345},
        {32'h40000000, 32'h7FC0BEEF, 32'hFFC00009, 32'hBF800000}, 1'b1, 1'b0, "R3");
    // R4: signed zeros and identical values, both orders and modes
    run({32'h00000000, 32'h80000000, 32'h3F800000, 32'h80000000},
        {32'h80000000, 32'h00000000, 32'h3F800000, 32'h80000000}, 1'b0, 1'b0, "R4");
    run({32'h00000000, 32'h80000000, 32'h3F800000, 32'h80000000},
        {32'h80000000, 32'h00000000, 32'h3F800000, 32'h80000000}, 1'b1, 1'b0, "R4");
    // R5 / R6: mixed-sign, both-negative, both-positive, tiny vs zero
    run({32'hBF800000, 32'hC0000000, 32'h3F800000, 32'h00000001},
        {32'h3F800000, 32'hBF800000, 32'h40000000, 32'h80000000}, 1'b0, 1'b0, "R5");
    run({32'hBF800000, 32'hC0000000, 32'h3F800000, 32'h00000001},
        {32'h3F800000, 32'hBF800000, 32'h40000000, 32'h80000000}, 1'b1, 1'b0, "R6");
    // R7: infinities against extremes
    run({32'hFF800000, 32'h7F800000, 32'hFF7FFFFF, 32'h7F800000},
        {32'hFF7FFFFF, 32'h7F7FFFFF, 32'h7F800000, 32'hFF800000}, 1'b0, 1'b0, "R7");
    run({32'hFF800000, 32'h7F800000, 32'hFF7FFFFF, 32'h7F800000},
        {32'hFF7FFFFF, 32'h7F7FFFFF, 32'h7F800000, 32'hFF800000}, 1'b1, 1'b0, "R7");
    // R8: scalar keeps upper destination lanes
    run({32'h11111111, 32'h22222222, 32'h33333333, 32'h40400000},
        {32'h7FC00000, 32'h00000000, 32'hFF800000, 32'h3F800000}, 1'b0, 1'b1, "R8");
    run({32'h11111111, 32'h22222222, 32'h33333333, 32'h40400000},
        {32'h7FC00000, 32'h00000000, 32'hFF800000, 32'h3F800000}, 1'b1, 1'b1, "R8");

    // R9: random lanes with special values mixed in
    for (int n = 0; n < 400; n++) begin
      logic [127:0] d, s;
      for (int k = 0; k < 4; k++) begin
        d[k*32 +: 32] = pick();
        s[k*32 +: 32] = ($urandom_range(7, 0) == 0) ? d[k*32 +: 32] : pick();
      end
      run(d, s, 1'($urandom_range(1, 0)), ($urandom_range(3, 0) == 0), "R9");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule